// File: doc/BRIEF.md
# Watchdog Timer with Protected Configuration

This block supervises software by counting cycles of a watchdog clock enable and acting when the count runs out. Software restarts the count with a kick pulse. If the count expires, the block does nothing, raises an interrupt request, issues a one-cycle system reset pulse, or raises an interrupt first and issues the reset on the following expiry if the interrupt is still unserviced. Which of these happens depends on two enable bits in an 8-bit control/status register and on an always-on configuration input.

Changes to the time-out length, and any attempt to turn the reset enable off, are protected by a timed unlock: a write that sets both the unlock bit and the reset-enable bit opens a four-clock window, and only a write inside that window can carry new prescale values or a cleared reset enable. An external reset-flag input pins the reset enable on until the flag is removed, so a supervised system that has already failed keeps restarting into a supervised state.

The time-out is `2^(MIN_LOG2 + code)` counted cycles for a 4-bit code from 0 to 9. With the default `MIN_LOG2` of 11 this spans 2048 to 1048576 cycles.

Top module: `wdog_guard`

## Requirements
- R1: After the synchronous reset `rd_data` reads 0x00 (with `rst_flag` low), `irq` is 0 and `sys_rst` is 0.
- R2: In an active mode, the time-out fires `2^(MIN_LOG2+code)` counted cycles after a kick, where the prescale code is register bit 5 (code MSB) concatenated with bits 2..0; the count then restarts from zero.
- R3: Prescale codes 10 to 15 give the same time-out as code 9.
- R4: The count advances only on clock edges where `tick` is 1.
- R5: Outside the unlock window, a write leaves the prescale bits unchanged and cannot clear the reset-enable bit (bit 3); writing 1 to bit 3 is always accepted.
- R6: A write with bit 4 (unlock) and bit 3 both 1 opens the window; bit 4 then reads 1 for four clocks; writes on the next four clock edges are accepted and any accepted write other than an opening one closes the window.
- R7: While `rst_flag` is 1, bit 3 reads 1 and stays 1 in the register even against a write of 0 inside the window.
- R8: Mode: `always_on`=1 gives reset mode; otherwise bit 6 (interrupt enable) and bit 3 select stopped (both 0), interrupt (bit 6 only), reset (bit 3 only) or interrupt-then-reset (both). When stopped, nothing fires.
- R9: In interrupt mode a time-out sets bit 7 (interrupt flag); `irq` is bit 7 AND bit 6; bit 7 is cleared by writing 1 to it or by `irq_ack`, and the acknowledge leaves bit 6 set.
- R10: In interrupt-then-reset mode a time-out raises `irq` without a reset; `irq_ack` clears bits 7 and 6, so the block is then in reset mode.
- R11: In interrupt-then-reset mode, a time-out while bit 7 is still set issues `sys_rst`.
- R12: `sys_rst` is a pulse of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Watchdog clock enable; count advances when 1 |
| kick | input | 1 | Restart the count from zero |
| wr_en | input | 1 | Write strobe for the control/status register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| irq_ack | input | 1 | Interrupt acknowledge |
| always_on | input | 1 | Forces reset mode |
| rst_flag | input | 1 | External reset flag; pins the reset enable on |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
A kick on edge K restarts the count, so with `tick` held high the action of a time-out is registered on edge K+2^(MIN_LOG2+code): `sys_rst` and the interrupt flag are sampled half a clock after that edge and again half a clock after the edge before it, where they must still be low. Register writes take effect on the edge that samples `wr_en`, so `rd_data` is read at the following falling edge, and the window checks count edges from the opening write to separate the fourth (accepted) from the fifth (rejected). With `tick` toggling, the bench drives the enable itself edge by edge so the sixteenth counted edge, and the pulse after it, fall on a known cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int CODE_W = 4;

  localparam int B_FLAG  = 7;
  localparam int B_IEN   = 6;
  localparam int B_PHI   = 5;
  localparam int B_UNLK  = 4;
  localparam int B_REN   = 3;

  typedef enum logic [1:0] {
    WD_STOP    = 2'd0,
    WD_INT     = 2'd1,
    WD_RST     = 2'd2,
    WD_INT_RST = 2'd3
  } wd_mode_e;

  function automatic wd_mode_e pick_mode(input logic force_on,
                                         input logic ren,
                                         input logic ien);
    if (force_on) return WD_RST;
    case ({ren, ien})
      2'b01:   return WD_INT;
      2'b10:   return WD_RST;
      2'b11:   return WD_INT_RST;
      default: return WD_STOP;
    endcase
  endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rst_flag,
  input  logic              set_flag,
  input  logic              ack,
  input  logic              clr_ien,
  output logic              flag_q,
  output logic              ien_q,
  output logic              ren_eff,
  output logic [CODE_W-1:0] code_q,
  output logic [7:0]        rd_data
);

  localparam int WIN_W = $clog2(UNLOCK_CYCLES + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             win_open;
  logic             open_wr;
  logic             ren_q;

  assign win_open = (win_cnt != '0);
  assign open_wr  = wr_en && wr_data[B_UNLK] && wr_data[B_REN];
  assign ren_eff  = ren_q | rst_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      code_q  <= '0;
      ren_q   <= 1'b0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (open_wr)       win_cnt <= WIN_W'(UNLOCK_CYCLES);
      else if (wr_en)    win_cnt <= '0;
      else if (win_open) win_cnt <= win_cnt - WIN_W'(1);

      if (wr_en && win_open)
        code_q <= {wr_data[B_PHI], wr_data[2:0]};

      if (rst_flag)
        ren_q <= 1'b1;
      else if (wr_en && wr_data[B_REN])
        ren_q <= 1'b1;
      else if (wr_en && win_open)
        ren_q <= 1'b0;

      if (clr_ien)    ien_q <= 1'b0;
      else if (wr_en) ien_q <= wr_data[B_IEN];

      if (set_flag)
        flag_q <= 1'b1;
      else if (ack || (wr_en && wr_data[B_FLAG]))
        flag_q <= 1'b0;
    end
  end

  assign rd_data = {flag_q, ien_q, code_q[3], win_open, ren_eff, code_q[2:0]};

  // R5: a write outside the window leaves the prescale code alone
  a_r5_code_guarded: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !win_open) |=> (code_q == $past(code_q)));

  // R5: reset enable cannot drop without the window
  a_r5_ren_guarded: assert property (@(posedge clk) disable iff (rst)
    (ren_q && !win_open) |=> ren_q);

  // R6: without writes the window counts down one per clock
  a_r6_window_countdown: assert property (@(posedge clk) disable iff (rst)
    (win_open && !wr_en) |=> (win_cnt == $past(win_cnt) - WIN_W'(1)));

  // R7: the reset flag pins the stored enable on
  a_r7_flag_pins_ren: assert property (@(posedge clk) disable iff (rst)
    rst_flag |=> ren_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int MIN_LOG2 = 11,
  parameter int MAX_CODE = 9,
  parameter int CNT_W    = MIN_LOG2 + MAX_CODE + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              kick,
  input  logic [CODE_W-1:0] code,
  output logic              expire
);

  logic [CODE_W-1:0] code_sat;
  logic [CNT_W-1:0]  terminal;
  logic [CNT_W-1:0]  cnt;

  assign code_sat = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
  assign terminal = (CNT_W'(1) << (MIN_LOG2 + int'(code_sat))) - CNT_W'(1);
  assign expire   = run && tick && (cnt >= terminal);

  always_ff @(posedge clk) begin
    if (rst || !run || kick || expire) cnt <= '0;
    else if (tick)                     cnt <= cnt + CNT_W'(1);
  end

  // R4: no tick, no progress
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !kick) |=> (cnt == $past(cnt)));

  // R2: a kick restarts the count from zero
  a_r2_kick_restarts: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int MIN_LOG2      = 11,
  parameter int MAX_CODE      = 9,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_ack,
  input  logic       always_on,
  input  logic       rst_flag,
  output logic       irq,
  output logic       sys_rst
);

  localparam int CNT_W = MIN_LOG2 + MAX_CODE + 1;

  wd_mode_e          mode;
  logic              flag_q, ien_q, ren_eff;
  logic [CODE_W-1:0] code_q;
  logic              expire;
  logic              set_flag, fire_rst, clr_ien;

  assign mode     = pick_mode(always_on, ren_eff, ien_q);
  assign set_flag = expire && ((mode == WD_INT) || ((mode == WD_INT_RST) && !flag_q));
  assign fire_rst = expire && ((mode == WD_RST) || ((mode == WD_INT_RST) && flag_q));
  assign clr_ien  = irq_ack && (mode == WD_INT_RST);

  wdog_ctrl_reg #(
    .UNLOCK_CYCLES(UNLOCK_CYCLES)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rst_flag (rst_flag),
    .set_flag (set_flag),
    .ack      (irq_ack),
    .clr_ien  (clr_ien),
    .flag_q   (flag_q),
    .ien_q    (ien_q),
    .ren_eff  (ren_eff),
    .code_q   (code_q),
    .rd_data  (rd_data)
  );

  wdog_counter #(
    .MIN_LOG2 (MIN_LOG2),
    .MAX_CODE (MAX_CODE),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (mode != WD_STOP),
    .tick   (tick),
    .kick   (kick),
    .code   (code_q),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) sys_rst <= 1'b0;
    else     sys_rst <= fire_rst;
  end

  assign irq = flag_q & ien_q;

  // R12: the reset pulse lasts one clock
  a_r12_one_cycle_reset: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> !sys_rst);

  // R10: acknowledge in combined mode removes the interrupt enable
  a_r10_ack_drops_ien: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && (mode == WD_INT_RST)) |=> !ien_q);

  // R11: unserviced interrupt at the next expiry leads to reset
  a_r11_unserviced_resets: assert property (@(posedge clk) disable iff (rst)
    (expire && (mode == WD_INT_RST) && flag_q) |=> sys_rst);

  // R8: stopped mode never resets
  a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == WD_STOP) |=> !sys_rst);

endmodule

// File: tb/sim_wdog_guard.sv
`timescale 1ns/1ps
module sim_wdog_guard;

  localparam int TB_LOG2 = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_ack = 1'b0;
  logic       always_on = 1'b0;
  logic       rst_flag = 1'b0;
  logic       irq;
  logic       sys_rst;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wdog_guard #(.MIN_LOG2(TB_LOG2), .MAX_CODE(9), .UNLOCK_CYCLES(4)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_ack(irq_ack), .always_on(always_on), .rst_flag(rst_flag),
    .irq(irq), .sys_rst(sys_rst)
  );

  // {code[31:28], expected cycles[27:0]} for R2 and R3
  localparam logic [31:0] VEC [6] = '{
    {4'd0,  28'd16},
    {4'd1,  28'd32},
    {4'd3,  28'd128},
    {4'd9,  28'd8192},
    {4'd10, 28'd8192},
    {4'd15, 28'd8192}
  };

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic finish_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      finish_all();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 sys_rst", sys_rst, 0);

    // R2 / R3 time-out lengths in reset mode
    for (int i = 0; i < 6; i++) begin
      logic [3:0] c;
      int unsigned n;
      c = VEC[i][31:28];
      n = VEC[i][27:0];
      wr(8'h18);
      wr({2'b00, c[3], 1'b0, 1'b1, c[2:0]});
      do_kick();
      idle(int'(n) - 1);
      check(c > 9 ? "R3 no early reset" : "R2 no early reset", sys_rst, 0);
      idle(1);
      check(c > 9 ? "R3 reset on time" : "R2 reset on time", sys_rst, 1);
      idle(1);
      check("R12 pulse one cycle", sys_rst, 0);
    end

    do_reset();
    // R5 guard outside window
    wr(8'h27);
    check("R5 prescale write rejected", rd_data, 8'h00);
    wr(8'h08);
    check("R5 set reset enable accepted", rd_data, 8'h08);
    wr(8'h00);
    check("R5 clear reset enable rejected", rd_data, 8'h08);

    // R6 window timing
    wr(8'h18);
    check("R6 window open", rd_data, 8'h18);
    idle(3);
    check("R6 unlock bit still set", rd_data, 8'h18);
    wr(8'h01);
    check("R6 fourth clock accepted", rd_data, 8'h01);
    wr(8'h18);
    check("R6 reopen", rd_data, 8'h19);
    idle(4);
    check("R6 unlock bit cleared", rd_data, 8'h09);
    wr(8'h02);
    check("R6 fifth clock rejected", rd_data, 8'h09);
    wr(8'h18);
    wr(8'h08);
    check("R6 write closes window", rd_data, 8'h08);
    wr(8'h00);
    check("R6 closed after write", rd_data, 8'h08);

    // R7 reset flag override
    rst_flag = 1'b1;
    idle(1);
    wr(8'h18);
    wr(8'h00);
    check("R7 flag keeps reset enable", rd_data, 8'h08);
    rst_flag = 1'b0;
    idle(1);
    check("R7 enable sticky after flag", rd_data, 8'h08);
    wr(8'h18);
    wr(8'h00);
    check("R7 cleared once flag gone", rd_data, 8'h00);

    // R8 stopped: nothing fires
    begin
      int hits = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sys_rst || irq) hits++;
      end
      check("R8 stopped quiet", hits, 0);
    end

    // R9 interrupt mode
    wr(8'h40);
    do_kick();
    idle(15);
    check("R9 no early irq", irq, 0);
    idle(1);
    check("R9 irq on time-out", irq, 1);
    check("R9 flag set", rd_data, 8'hC0);
    check("R9 no reset in interrupt mode", sys_rst, 0);
    wr(8'hC0);
    check("R9 write-one clears flag", rd_data, 8'h40);
    check("R9 irq dropped", irq, 0);
    do_kick();
    idle(16);
    check("R9 irq again", irq, 1);
    do_ack();
    check("R9 ack clears flag keeps enable", rd_data, 8'h40);

    // R10 combined mode, serviced
    wr(8'h48);
    do_kick();
    idle(16);
    check("R10 irq first", irq, 1);
    check("R10 no reset first", sys_rst, 0);
    do_ack();
    check("R10 ack clears flag and enable", rd_data, 8'h08);
    do_kick();
    idle(16);
    check("R10 reset mode after service", sys_rst, 1);

    // R11 combined mode, unserviced
    wr(8'h48);
    do_kick();
    idle(16);
    check("R11 irq first", irq, 1);
    check("R11 no reset first", sys_rst, 0);
    idle(15);
    check("R11 no early reset", sys_rst, 0);
    idle(1);
    check("R11 reset on second time-out", sys_rst, 1);

    // R8 always-on forces reset mode
    wr(8'h18);
    wr(8'h80);
    check("R8 stopped config", rd_data, 8'h00);
    always_on = 1'b1;
    do_kick();
    idle(16);
    check("R8 always-on resets", sys_rst, 1);

    // R4 tick gating: ticks on every second edge
    tick = 1'b0;
    do_kick();
    begin
      int early = 0;
      for (int i = 1; i <= 32; i++) begin
        if (i > 1 && sys_rst) early++;
        tick = (i % 2 == 0);
        @(negedge clk);
      end
      check("R4 no reset before 16 ticks", early, 0);
      check("R4 reset on 16th tick", sys_rst, 1);
    end
    tick = 1'b1;
    always_on = 1'b0;

    done = 1'b1;
    finish_all();
  end

endmodule